// File: doc/BRIEF.md
# In-Band Packet-End Stream Encoder

This block takes a 64-bit valid/ready stream that has a sideband end-of-packet bit and produces a 64-bit stream without that bit. It marks each packet end inside the data. An end-of-packet word, or any word that happens to equal the reserved marker value `0xDEADBEEFFEEDCAFE`, is expanded into three output words: the marker, a flag word, and then the original word. The low half of the flag word tells a downstream decoder whether the third word ends a packet (1) or is only a literal copy of the marker value (0). Every other word passes straight through as a single word.

For packet ends, the upper half of the flag word carries a 32-bit running sum. The sum is built from the earlier words of the packet, so the receiver can check the packet's integrity. The block holds no copy of the input. While the marker and the flag are being sent, it holds the input off. It consumes the input word in the same handshake in which that word's own copy leaves the output. Back-pressure on the output therefore reaches the input directly, and no word is lost or repeated.

Top module: `stream_eop_escaper`

## Requirements
- R1: An input word that is not equal to `0xDEADBEEFFEEDCAFE` and has `in_last` high is emitted as three words: first `0xDEADBEEFFEEDCAFE`, then a flag word with bits [31:0] = 1, then the input word unchanged.
- R2: An input word equal to `0xDEADBEEFFEEDCAFE` with `in_last` low is emitted as the marker, then an all-zero flag word, then the marker value again.
- R3: An input word equal to `0xDEADBEEFFEEDCAFE` with `in_last` high is emitted as the marker, then a flag word with bits [31:0] = 1, then the marker value again.
- R4: Any other input word with `in_last` low is emitted unchanged as exactly one output word.
- R5: Bits [63:32] of a flag word whose low half is 1 equal the modulo-2^32 sum, over every earlier word of the same packet, of bits [31:0] plus bits [63:32]. The packet's last word is excluded.
- R6: The running sum returns to zero after a packet's last word is consumed. It also returns to zero on reset, and when `clr` is high for one cycle.
- R7: `in_ready` is low whenever the output is offering a marker or a flag word. An input word is consumed only in the cycle in which its own copy is accepted at the output.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. Under any pattern of output stalls, no word is dropped or duplicated.
- R9: After reset, with no input offered, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the running sum |
| in_data | input | 64 | Input word |
| in_valid | input | 1 | Input word offered |
| in_last | input | 1 | Input word ends a packet |
| in_ready | output | 1 | Block accepts the input word this cycle |
| out_data | output | 64 | Output word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
Suppose the sequencer takes a wrong step: it leaves the flag state early, or it drops back to pass-through before the data copy. The fault shows on the very next accepted output word. That word is then a raw data word where a flag was expected, or the input word is missing. Either way the word-by-word scoreboard flags it.

A running sum that is not cleared, or that adds the final word, goes unseen until the next packet end. It then shows as a wrong upper half in that packet's flag word. For this reason, single-word packets and packets that follow a clear are both driven.

A sequencer that lets the input go early shows within one cycle, as `in_ready` high while a marker or flag is being offered.

// File: rtl/eop_esc_pkg.sv
package eop_esc_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam logic [WORD_W-1:0] ESC_WORD = 64'hDEADBEEF_FEEDCAFE;

  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_ESC  = 2'd1,
    ST_FLAG = 2'd2,
    ST_DATA = 2'd3
  } seq_state_e;

  // Add both halves of a word into a wrapping accumulator.
  function automatic logic [HALF_W-1:0] fold_word(input logic [HALF_W-1:0] acc,
                                                  input logic [WORD_W-1:0] w);
    return acc + w[HALF_W-1:0] + w[WORD_W-1:HALF_W];
  endfunction

  // Flag word: low half is the end marker, high half the sum (ends only).
  function automatic logic [WORD_W-1:0] make_flag(input logic [HALF_W-1:0] acc,
                                                  input logic fin);
    logic [WORD_W-1:0] f;
    f = '0;
    if (fin) begin
      f[HALF_W-1:0]      = {{(HALF_W-1){1'b0}}, 1'b1};
      f[WORD_W-1:HALF_W] = acc;
    end
    return f;
  endfunction

  // A word needs the three-word form when it ends a packet or aliases the marker.
  function automatic logic needs_escape(input logic [WORD_W-1:0] w, input logic fin);
    return fin || (w == ESC_WORD);
  endfunction
endpackage

// File: rtl/eop_esc_sum.sv
module eop_esc_sum import eop_esc_pkg::*; #(
  parameter int unsigned DW = WORD_W,
  localparam int unsigned HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          take,
  input  logic          fin,
  input  logic [DW-1:0] word,
  output logic [HW-1:0] acc
);
  logic          wipe;
  logic [HW-1:0] acc_next;

  assign wipe     = rst || clr || (take && fin);
  assign acc_next = fold_word(acc, word);

  always_ff @(posedge clk) begin
    if (wipe)      acc <= '0;
    else if (take) acc <= acc_next;
  end

  AST_SUM_WIPED: assert property (@(posedge clk) disable iff (rst)
    ((take && fin) || clr) |=> (acc == '0)); // R6

  AST_SUM_HELD: assert property (@(posedge clk) disable iff (rst)
    (!take && !clr) |=> $stable(acc)); // R5
endmodule

// File: rtl/eop_esc_seq.sv
module eop_esc_seq import eop_esc_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       mark,
  input  logic       out_fire,
  output seq_state_e state
);
  seq_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_PASS: if (in_valid && mark) state_nx = out_fire ? ST_FLAG : ST_ESC;
      ST_ESC:  if (out_fire) state_nx = ST_FLAG;
      ST_FLAG: if (out_fire) state_nx = ST_DATA;
      ST_DATA: if (out_fire) state_nx = ST_PASS;
      default: state_nx = ST_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_PASS;
    else     state <= state_nx;
  end

  AST_ESC_THEN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ESC && out_fire) |=> (state == ST_FLAG)); // R1

  AST_FLAG_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLAG && out_fire) |=> (state == ST_DATA)); // R1

  AST_STALL_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    (state != ST_PASS && !out_fire) |=> $stable(state)); // R8
endmodule

// File: rtl/eop_esc_mux.sv
module eop_esc_mux import eop_esc_pkg::*; #(
  parameter int unsigned DW = WORD_W
) (
  input  seq_state_e    state,
  input  logic          mark,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic [DW-1:0] flag_word,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          in_ready
);
  always_comb begin
    out_data  = in_data;
    out_valid = in_valid;
    in_ready  = out_ready;
    unique case (state)
      ST_PASS: if (in_valid && mark) begin
        out_data  = ESC_WORD;
        out_valid = 1'b1;
        in_ready  = 1'b0;
      end
      ST_ESC: begin
        out_data  = ESC_WORD;
        out_valid = 1'b1;
        in_ready  = 1'b0;
      end
      ST_FLAG: begin
        out_data  = flag_word;
        out_valid = 1'b1;
        in_ready  = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stream_eop_escaper.sv
module stream_eop_escaper import eop_esc_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  logic              mark;
  logic              in_fire;
  logic              out_fire;
  logic [HALF_W-1:0] run_sum;
  logic [WORD_W-1:0] flag_word;
  seq_state_e        state;

  assign mark      = needs_escape(in_data, in_last);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign flag_word = make_flag(run_sum, in_last);

  eop_esc_sum #(.DW(WORD_W)) u_sum (
    .clk(clk), .rst(rst), .clr(clr), .take(in_fire), .fin(in_last),
    .word(in_data), .acc(run_sum)
  );

  eop_esc_seq u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mark(mark),
    .out_fire(out_fire), .state(state)
  );

  eop_esc_mux #(.DW(WORD_W)) u_mux (
    .state(state), .mark(mark), .in_data(in_data), .in_valid(in_valid),
    .flag_word(flag_word), .out_ready(out_ready), .out_data(out_data),
    .out_valid(out_valid), .in_ready(in_ready)
  );

  AST_IN_ONLY_WITH_OUT: assert property (@(posedge clk) disable iff (rst)
    in_fire |-> (out_fire && out_data == in_data)); // R7

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_ALIAS_FLAG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLAG && !in_last) |-> (out_valid && out_data == '0)); // R2

  AST_END_FLAG_LOW_ONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLAG && in_last) |-> (out_data[HALF_W-1:0] == 1)); // R3
endmodule

// File: tb/stream_eop_escaper_tb.sv
module stream_eop_escaper_tb;
  localparam logic [63:0] ESC = 64'hDEADBEEF_FEEDCAFE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [63:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  int stall_pct = 0;
  logic [31:0] m_sum = '0;
  bit after_clr = 1'b0;

  logic [63:0] exp_q[$];
  int          kind_q[$];  // 0 data, 1 marker, 2 flag
  string       tag_q[$];

  logic        prev_stall = 1'b0;
  logic [63:0] prev_data = '0;

  always #4 clk = ~clk;  // 125 MHz

  stream_eop_escaper u_dut (
    .clk(clk), .rst(rst), .clr(clr), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic push(input logic [63:0] d, input int k, input string t);
    exp_q.push_back(d); kind_q.push_back(k); tag_q.push_back(t);
  endtask

  // Driver: model expected output words, then offer the word until accepted.
  task automatic send(input logic [63:0] d, input logic l);
    bit hs;
    if (l || d == ESC) begin
      string t;
      t = (l && d == ESC) ? "R3" : (l ? "R1" : "R2");
      push(ESC, 1, t);
      if (l) push({m_sum, 32'h1}, 2, after_clr ? "R6" : "R5");
      else   push(64'h0, 2, "R2");
      push(d, 0, t);
      if (l) after_clr = 1'b0;
    end else begin
      push(d, 0, "R4");
    end
    if (l) m_sum = '0;
    else   m_sum = m_sum + d[31:0] + d[63:32];
    in_data = d; in_last = l; in_valid = 1'b1;
    do begin
      @(negedge clk); hs = in_ready;
      @(posedge clk); #1;
    end while (!hs);
    in_valid = 1'b0;
    in_data = {$urandom, $urandom};
    in_last = 1'($urandom);
    if (($urandom % 4) == 0) begin @(posedge clk); #1; end
  endtask

  function automatic logic [63:0] rnd_word();
    if (($urandom % 5) == 0) return ESC;
    return {$urandom, $urandom};
  endfunction

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(posedge clk); #1; n++; end
  endtask

  // Output back-pressure.
  initial forever begin
    @(posedge clk); #1;
    out_ready = (($urandom % 100) >= stall_pct);
  end

  // Monitor: compare each accepted output word with the queue head.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R8 stall hold", out_data, prev_data);
      if (out_valid && exp_q.size() != 0 && kind_q[0] != 0)
        check(in_ready == 1'b0, "R7 input held", {63'b0, in_ready}, 64'h0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 extra word", out_data, 64'h0);
        end else begin
          check(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
          void'(exp_q.pop_front()); void'(kind_q.pop_front()); void'(tag_q.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 reset idle", {63'b0, out_valid}, 64'h0);
    @(posedge clk); #1;

    // Directed: plain words, aliased marker, ends of both kinds, wrap of sum.
    send(64'h0000_0001_0000_0002, 1'b0);       // R4
    send(ESC, 1'b0);                           // R2
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);       // R5 wraps
    send(64'h1234_5678_8765_4321, 1'b1);       // R1
    send(ESC, 1'b1);                           // R3 single-word packet
    send(64'h0000_0000_0000_0005, 1'b1);       // R6 sum zero after end
    drain();

    // Clear mid-packet: sum restarts from zero.
    send(64'h0000_0010_0000_0020, 1'b0);
    drain();
    @(posedge clk); #1 clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
    m_sum = '0; after_clr = 1'b1;
    send(64'h0000_0003_0000_0004, 1'b0);
    send(64'hAAAA_0000_BBBB_0000, 1'b1);       // R6 flag after clear
    drain();

    // Random packets under rising back-pressure.
    for (int p = 0; p < 3; p++) begin
      stall_pct = 20 + 30 * p;
      for (int k = 0; k < 40; k++) begin
        int len = 1 + ($urandom % 6);
        for (int w = 0; w < len; w++) send(rnd_word(), w == len - 1);
      end
      drain();
    end
    stall_pct = 0;
    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R8 all words delivered", 64'(exp_q.size()), 64'h0);
    summary();
    $finish;
  end
endmodule